// File: doc/BRIEF.md
# Static Chip-Select Controller With Wait States

This block sits between an internal request source and an external static memory bus with six active-low chip selects. A request carries a bank number, a 26-bit byte address inside that bank's 64 MB window, a direction, four byte enables and a requested beat count. The block drives the selected chip select, the read or write strobe, the byte-select lanes and the address. It also flags each completed data beat. Bank 0 starts at system address zero, so chip select 0 serves as the boot device.

Each chip select has its own configuration: a memory type, a bus width of 16 or 32 bits, a first-access wait count and a burst-beat wait count. The types are single-access ROM/flash, burst ROM/flash, SRAM and variable-latency I/O. Not every type may sit on every chip select. A type that is illegal for its chip select raises an error bit, and the chip select then runs as single-access ROM. Only variable-latency I/O looks at the external ready input. The block samples that input once the programmed wait has elapsed, and holds the access while ready is low.

Top module: `scs_ctrl`

## Requirements
- R1: A request with bank 0..5 drives `cs_n[bank]` low, and only that line, for the whole access, with `mem_addr` showing the request address. Bank 0 at address 0 is the boot device. A request with bank 6 or 7 is ignored: no chip select falls and `busy` stays low.
- R2: `cfg_type` holds 2 bits per chip select at bits [2i+1:2i], coded 0 = single ROM, 1 = burst ROM, 2 = SRAM, 3 = variable-latency I/O. SRAM is illegal on chip selects 3..5 and variable-latency I/O is illegal on 0..2. An illegal type sets `type_err[i]`, and that chip select then behaves as single ROM: byte selects stay high, ready is ignored and there is one beat.
- R3: During an access, `oe_n` is low for a read and `we_n` is low for a write. The two are never low together, and the strobes do not change within an access.
- R4: For SRAM and variable-latency I/O, `bs_n[k]` is the inverse of `req_be[k]`. On a 16-bit chip select, lanes 3:2 stay high. For both ROM types, and when idle, `bs_n` is all ones.
- R5: The strobes assert in the cycle after acceptance. The first beat completes (`beat_done` high) in strobe cycle `wait1 + 1`, where `wait1` is `cfg_wait1[4i+3:4i]`.
- R6: A read on a burst-ROM chip select carries `req_beats + 1` beats. Each later beat completes `waitb + 1` cycles after the previous one, where `waitb` is `cfg_waitb[4i+3:4i]`. `mem_addr` advances by 4 on a 32-bit chip select and by 2 on a 16-bit one (`cfg_wide[i]` = 1 means 32-bit).
- R7: A write, and any access to a type other than burst ROM, is a single beat whatever `req_beats` is.
- R8: For variable-latency I/O, `io_rdy` is sampled only once the wait count has run out. While it is low there, the beat is held off, and the beat completes in the first such cycle where it is high. For all other types `io_rdy` has no effect.
- R9: After the final beat, all strobes deassert in the next cycle. At least one idle cycle separates two accesses. A request made while `busy` is high is ignored.
- R10: In and after reset, all chip selects, `oe_n`, `we_n` and `bs_n` are high, and `busy` and `beat_done` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_type | input | 12 | Memory type per chip select, 2 bits each |
| cfg_wide | input | 6 | 1 = 32-bit bus, 0 = 16-bit bus, per chip select |
| cfg_wait1 | input | 24 | First-access wait count, 4 bits per chip select |
| cfg_waitb | input | 24 | Burst-beat wait count, 4 bits per chip select |
| req_valid | input | 1 | Request present (taken when idle) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_bank | input | 3 | Chip-select number |
| req_addr | input | 26 | Byte address within the bank |
| req_be | input | 4 | Byte enables, lane k active high |
| req_beats | input | 2 | Extra beats for a burst read |
| io_rdy | input | 1 | Ready from variable-latency devices |
| busy | output | 1 | Access in progress |
| beat_done | output | 1 | A data beat completes this cycle |
| cs_n | output | 6 | Active-low chip selects |
| oe_n | output | 1 | Active-low output enable |
| we_n | output | 1 | Active-low write enable |
| bs_n | output | 4 | Active-low byte selects |
| mem_addr | output | 26 | Byte address to memory |
| type_err | output | 6 | Illegal-type flag per chip select |

## Verification
The assertions check the following on every cycle:
- at most one chip select is low, and the two strobes are never low together;
- the strobes hold steady for the whole access;
- ROM-type accesses keep the byte selects high;
- an access ends only on a completed beat, and a write ends after its first beat;
- each burst beat moves the address by the bus width;
- no beat completes on a variable-latency chip select while ready is low;
- no chip select ever runs a type that is illegal for it.

Only the bench scenarios can show the following:
- the exact cycle each beat lands relative to the programmed wait counts;
- that ready is ignored before the wait runs out and on other types;
- the byte-lane patterns on 16-bit and 32-bit buses;
- the idle gap between back-to-back accesses;
- that requests to banks 6 and 7, or made while busy, are dropped.

// File: rtl/scs_pkg.sv
package scs_pkg;

  // Memory type codes, 2 bits per chip select
  typedef enum logic [1:0] {
    MT_ROM  = 2'd0,
    MT_BROM = 2'd1,
    MT_SRAM = 2'd2,
    MT_VLIO = 2'd3
  } mem_type_e;

  // SRAM is allowed below the split index, variable-latency I/O at or above it
  function automatic logic type_legal(input mem_type_e t, input int unsigned idx,
                                      input int unsigned split);
    case (t)
      MT_SRAM: type_legal = (idx < split);
      MT_VLIO: type_legal = (idx >= split);
      default: type_legal = 1'b1;
    endcase
  endfunction

  // Byte selects qualify the access only for these types
  function automatic logic uses_lanes(input mem_type_e t);
    uses_lanes = (t == MT_SRAM) || (t == MT_VLIO);
  endfunction

endpackage

// File: rtl/scs_cfg_check.sv
module scs_cfg_check
  import scs_pkg::*;
#(
  parameter int N_CS    = 6,
  parameter int SRAM_CS = 3
) (
  input  logic [2*N_CS-1:0] cfg_type,
  output logic [2*N_CS-1:0] eff_type,
  output logic [N_CS-1:0]   type_err
);

  for (genvar i = 0; i < N_CS; i++) begin : g_cs
    mem_type_e raw_type;
    mem_type_e use_type;

    assign raw_type    = mem_type_e'(cfg_type[2*i +: 2]);
    assign type_err[i] = !type_legal(raw_type, i, SRAM_CS);
    assign use_type    = type_err[i] ? MT_ROM : raw_type;
    assign eff_type[2*i +: 2] = use_type;

    if (i < SRAM_CS) begin : g_low
      // R2
      always_comb begin
        no_vlio_low_chk: assert (mem_type_e'(eff_type[2*i +: 2]) != MT_VLIO);
      end
    end else begin : g_high
      // R2
      always_comb begin
        no_sram_high_chk: assert (mem_type_e'(eff_type[2*i +: 2]) != MT_SRAM);
      end
    end
  end

endmodule

// File: rtl/scs_seq.sv
module scs_seq
  import scs_pkg::*;
#(
  parameter int N_CS   = 6,
  parameter int ADDR_W = 26,
  parameter int WAIT_W = 4,
  parameter int BEAT_W = 2,
  parameter int BS_W   = 4,
  parameter int BANK_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [BANK_W-1:0] req_bank,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [BS_W-1:0]   req_be,
  input  logic [BEAT_W-1:0] req_beats,
  input  mem_type_e         sel_type,
  input  logic              sel_wide,
  input  logic [WAIT_W-1:0] sel_wait1,
  input  logic [WAIT_W-1:0] sel_waitb,
  input  logic              io_rdy,
  output logic              busy,
  output logic              beat_done,
  output logic [BANK_W-1:0] cur_bank,
  output logic              cur_write,
  output mem_type_e         cur_type,
  output logic              cur_wide,
  output logic [BS_W-1:0]   cur_be,
  output logic [ADDR_W-1:0] cur_addr
);

  localparam logic [ADDR_W-1:0] STEP_W32 = ADDR_W'(BS_W);
  localparam logic [ADDR_W-1:0] STEP_W16 = ADDR_W'(BS_W / 2);

  typedef enum logic {ST_IDLE = 1'b0, ST_ACT = 1'b1} seq_state_e;

  seq_state_e        state_q, state_d;
  logic [BANK_W-1:0] bank_q;
  logic              write_q;
  mem_type_e         type_q;
  logic              wide_q;
  logic [BS_W-1:0]   be_q;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [WAIT_W-1:0] cnt_q, cnt_d;
  logic [WAIT_W-1:0] waitb_q;
  logic [BEAT_W-1:0] left_q, left_d;

  logic bank_ok, accept, cnt_zero, rdy_ok, beat, last_beat;
  logic ld_req, en_cnt, en_addr, en_left;

  // Next-state logic
  assign bank_ok   = ({1'b0, req_bank} < (BANK_W + 1)'(N_CS));
  assign accept    = (state_q == ST_IDLE) && req_valid && bank_ok;
  assign cnt_zero  = (cnt_q == '0);
  assign rdy_ok    = (type_q != MT_VLIO) || io_rdy;
  assign beat      = (state_q == ST_ACT) && cnt_zero && rdy_ok;
  assign last_beat = (left_q == '0);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    addr_d  = addr_q;
    left_d  = left_q;
    ld_req  = 1'b0;
    en_cnt  = 1'b0;
    en_addr = 1'b0;
    en_left = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (accept) begin
          state_d = ST_ACT;
          ld_req  = 1'b1;
          en_cnt  = 1'b1;
          en_addr = 1'b1;
          en_left = 1'b1;
          cnt_d   = sel_wait1;
          addr_d  = req_addr;
          left_d  = (sel_type == MT_BROM && !req_write) ? req_beats : '0;
        end
      end
      default: begin
        if (!cnt_zero) begin
          en_cnt = 1'b1;
          cnt_d  = cnt_q - 1'b1;
        end else if (beat) begin
          if (last_beat) begin
            state_d = ST_IDLE;
          end else begin
            en_cnt  = 1'b1;
            en_addr = 1'b1;
            en_left = 1'b1;
            cnt_d   = waitb_q;
            left_d  = left_q - 1'b1;
            addr_d  = addr_q + (wide_q ? STEP_W32 : STEP_W16);
          end
        end
      end
    endcase
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bank_q  <= '0;
      write_q <= 1'b0;
      type_q  <= MT_ROM;
      wide_q  <= 1'b0;
      be_q    <= '0;
      waitb_q <= '0;
    end else if (ld_req) begin
      bank_q  <= req_bank;
      write_q <= req_write;
      type_q  <= sel_type;
      wide_q  <= sel_wide;
      be_q    <= req_be;
      waitb_q <= sel_waitb;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (en_cnt) begin
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
    end else if (en_addr) begin
      addr_q <= addr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left_q <= '0;
    end else if (en_left) begin
      left_q <= left_d;
    end
  end

  assign busy      = (state_q == ST_ACT);
  assign beat_done = beat;
  assign cur_bank  = bank_q;
  assign cur_write = write_q;
  assign cur_type  = type_q;
  assign cur_wide  = wide_q;
  assign cur_be    = be_q;
  assign cur_addr  = addr_q;

  // R6
  burst_only_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && (write_q || type_q != MT_BROM)) |-> (left_q == '0));

endmodule

// File: rtl/scs_drive.sv
module scs_drive
  import scs_pkg::*;
#(
  parameter int N_CS   = 6,
  parameter int BS_W   = 4,
  parameter int BANK_W = 3
) (
  input  logic              busy,
  input  logic [BANK_W-1:0] cur_bank,
  input  logic              cur_write,
  input  mem_type_e         cur_type,
  input  logic              cur_wide,
  input  logic [BS_W-1:0]   cur_be,
  output logic [N_CS-1:0]   cs_n,
  output logic              oe_n,
  output logic              we_n,
  output logic [BS_W-1:0]   bs_n
);

  localparam int HALF_W = BS_W / 2;

  logic lanes_on;

  assign lanes_on = busy && uses_lanes(cur_type);

  for (genvar c = 0; c < N_CS; c++) begin : g_sel
    assign cs_n[c] = !(busy && (cur_bank == BANK_W'(c)));
  end

  for (genvar l = 0; l < BS_W; l++) begin : g_lane
    if (l < HALF_W) begin : g_lo
      assign bs_n[l] = !(lanes_on && cur_be[l]);
    end else begin : g_hi
      assign bs_n[l] = !(lanes_on && cur_wide && cur_be[l]);
    end
  end

  assign oe_n = !(busy && !cur_write);
  assign we_n = !(busy && cur_write);

  // R1
  always_comb begin
    one_select_chk: assert ($onehot0(~cs_n));
  end

endmodule

// File: rtl/scs_ctrl.sv
module scs_ctrl
  import scs_pkg::*;
#(
  parameter int N_CS    = 6,
  parameter int SRAM_CS = 3,
  parameter int ADDR_W  = 26,
  parameter int WAIT_W  = 4,
  parameter int BEAT_W  = 2,
  parameter int BS_W    = 4,
  parameter int BANK_W  = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [2*N_CS-1:0]        cfg_type,
  input  logic [N_CS-1:0]          cfg_wide,
  input  logic [WAIT_W*N_CS-1:0]   cfg_wait1,
  input  logic [WAIT_W*N_CS-1:0]   cfg_waitb,
  input  logic                     req_valid,
  input  logic                     req_write,
  input  logic [BANK_W-1:0]        req_bank,
  input  logic [ADDR_W-1:0]        req_addr,
  input  logic [BS_W-1:0]          req_be,
  input  logic [BEAT_W-1:0]        req_beats,
  input  logic                     io_rdy,
  output logic                     busy,
  output logic                     beat_done,
  output logic [N_CS-1:0]          cs_n,
  output logic                     oe_n,
  output logic                     we_n,
  output logic [BS_W-1:0]          bs_n,
  output logic [ADDR_W-1:0]        mem_addr,
  output logic [N_CS-1:0]          type_err
);

  localparam logic [ADDR_W-1:0] STEP_W32 = ADDR_W'(BS_W);
  localparam logic [ADDR_W-1:0] STEP_W16 = ADDR_W'(BS_W / 2);

  logic [2*N_CS-1:0] eff_type;
  mem_type_e         sel_type;
  logic              sel_wide;
  logic [WAIT_W-1:0] sel_wait1, sel_waitb;

  logic [BANK_W-1:0] cur_bank;
  logic              cur_write;
  mem_type_e         cur_type;
  logic              cur_wide;
  logic [BS_W-1:0]   cur_be;

  scs_cfg_check #(.N_CS(N_CS), .SRAM_CS(SRAM_CS)) u_cfg (
    .cfg_type (cfg_type),
    .eff_type (eff_type),
    .type_err (type_err)
  );

  // Per-bank configuration select
  always_comb begin
    sel_type  = MT_ROM;
    sel_wide  = 1'b0;
    sel_wait1 = '0;
    sel_waitb = '0;
    for (int i = 0; i < N_CS; i++) begin
      if (req_bank == BANK_W'(i)) begin
        sel_type  = mem_type_e'(eff_type[2*i +: 2]);
        sel_wide  = cfg_wide[i];
        sel_wait1 = cfg_wait1[WAIT_W*i +: WAIT_W];
        sel_waitb = cfg_waitb[WAIT_W*i +: WAIT_W];
      end
    end
  end

  scs_seq #(
    .N_CS(N_CS), .ADDR_W(ADDR_W), .WAIT_W(WAIT_W),
    .BEAT_W(BEAT_W), .BS_W(BS_W), .BANK_W(BANK_W)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_bank  (req_bank),
    .req_addr  (req_addr),
    .req_be    (req_be),
    .req_beats (req_beats),
    .sel_type  (sel_type),
    .sel_wide  (sel_wide),
    .sel_wait1 (sel_wait1),
    .sel_waitb (sel_waitb),
    .io_rdy    (io_rdy),
    .busy      (busy),
    .beat_done (beat_done),
    .cur_bank  (cur_bank),
    .cur_write (cur_write),
    .cur_type  (cur_type),
    .cur_wide  (cur_wide),
    .cur_be    (cur_be),
    .cur_addr  (mem_addr)
  );

  scs_drive #(.N_CS(N_CS), .BS_W(BS_W), .BANK_W(BANK_W)) u_drive (
    .busy      (busy),
    .cur_bank  (cur_bank),
    .cur_write (cur_write),
    .cur_type  (cur_type),
    .cur_wide  (cur_wide),
    .cur_be    (cur_be),
    .cs_n      (cs_n),
    .oe_n      (oe_n),
    .we_n      (we_n),
    .bs_n      (bs_n)
  );

  // R3
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!oe_n && !we_n));

  // R3
  strobe_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(cs_n) && $stable(oe_n) && $stable(we_n)));

  // R4
  rom_lanes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy || cur_type == MT_ROM || cur_type == MT_BROM) |-> (bs_n == '1));

  // R9
  end_on_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(beat_done));

  // R7
  write_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_done && !we_n) |=> !busy);

  // R8
  vlio_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cur_type == MT_VLIO && !io_rdy) |-> !beat_done);

  // R6
  burst_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && $past(beat_done)) |->
      (mem_addr == $past(mem_addr) + (cur_wide ? STEP_W32 : STEP_W16)));

endmodule

// File: tb/scs_ctrl_bench.sv
`timescale 1ns/1ps
module scs_ctrl_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] cfg_type;
  logic [5:0]  cfg_wide;
  logic [23:0] cfg_wait1;
  logic [23:0] cfg_waitb;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [2:0]  req_bank = '0;
  logic [25:0] req_addr = '0;
  logic [3:0]  req_be = '0;
  logic [1:0]  req_beats = '0;
  logic        io_rdy = 1'b1;
  logic        busy, beat_done, oe_n, we_n;
  logic [5:0]  cs_n, type_err;
  logic [3:0]  bs_n;
  logic [25:0] mem_addr;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  scs_ctrl u_scs_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_type(cfg_type), .cfg_wide(cfg_wide),
    .cfg_wait1(cfg_wait1), .cfg_waitb(cfg_waitb), .req_valid(req_valid),
    .req_write(req_write), .req_bank(req_bank), .req_addr(req_addr),
    .req_be(req_be), .req_beats(req_beats), .io_rdy(io_rdy), .busy(busy),
    .beat_done(beat_done), .cs_n(cs_n), .oe_n(oe_n), .we_n(we_n),
    .bs_n(bs_n), .mem_addr(mem_addr), .type_err(type_err)
  );

  task automatic check(input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic issue(input logic [2:0] b, input logic w, input logic [25:0] a,
                       input logic [3:0] be, input logic [1:0] nb);
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_bank = b;
    req_addr = a; req_be = be; req_beats = nb;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // Returns the strobe cycle (1-based) in which the beat completes
  task automatic wait_beat(output int n);
    n = 1;
    while (!beat_done && n < 64) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic t_reset();
    check("R10 cs_n", cs_n, 6'h3F);
    check("R10 oe_n/we_n", {oe_n, we_n}, 2'b11);
    check("R10 bs_n", bs_n, 4'hF);
    check("R10 busy/beat", {busy, beat_done}, 2'b00);
  endtask

  task automatic t_sram_read();
    int n;
    issue(3'd1, 1'b0, 26'h123456, 4'b0101, 2'd0);
    check("R1 cs1 selected", cs_n, 6'b111101);
    check("R1 address", mem_addr, 26'h123456);
    check("R3 read strobes", {oe_n, we_n}, 2'b01);
    check("R4 sram lanes", bs_n, 4'b1010);
    wait_beat(n);
    check("R5 first beat cycle", n, 3);
    @(negedge clk);
    check("R9 release", {busy, cs_n, oe_n, we_n}, {1'b0, 6'h3F, 2'b11});
  endtask

  task automatic t_write16();
    int n;
    issue(3'd0, 1'b1, 26'h0, 4'hF, 2'd3);
    check("R1 boot cs0", cs_n, 6'b111110);
    check("R3 write strobes", {oe_n, we_n}, 2'b10);
    check("R4 16-bit lanes", bs_n, 4'b1100);
    wait_beat(n);
    check("R5 zero wait beat", n, 1);
    @(negedge clk);
    check("R7 write single beat", busy, 1'b0);
  endtask

  task automatic t_burst();
    int n;
    issue(3'd5, 1'b0, 26'h100, 4'h0, 2'd3);
    check("R4 rom lanes", bs_n, 4'hF);
    wait_beat(n);
    check("R5 burst first beat", n, 4);
    for (int k = 1; k < 4; k++) begin
      @(negedge clk);
      check("R6 burst address 32", mem_addr, 26'h100 + 26'(4 * k));
      wait_beat(n);
      check("R6 burst beat cycle", n, 2);
    end
    @(negedge clk);
    check("R6 burst ends", busy, 1'b0);
    cfg_wide[5] = 1'b0;
    issue(3'd5, 1'b0, 26'h200, 4'h0, 2'd1);
    wait_beat(n);
    @(negedge clk);
    check("R6 burst address 16", mem_addr, 26'h202);
    wait_beat(n);
    @(negedge clk);
    check("R6 two beats", busy, 1'b0);
    issue(3'd5, 1'b1, 26'h300, 4'h0, 2'd3);
    wait_beat(n);
    check("R7 burst-rom write beat", n, 4);
    @(negedge clk);
    check("R7 burst-rom write single", busy, 1'b0);
    cfg_wide[5] = 1'b1;
  endtask

  task automatic t_illegal();
    int n;
    check("R2 type_err", type_err, 6'b001100);
    io_rdy = 1'b0;
    issue(3'd3, 1'b0, 26'h80, 4'b0011, 2'd2);
    check("R2 illegal as rom lanes", bs_n, 4'hF);
    wait_beat(n);
    check("R2 illegal ignores ready", n, 2);
    @(negedge clk);
    check("R2 illegal single beat", busy, 1'b0);
    io_rdy = 1'b1;
  endtask

  task automatic t_vlio();
    int n;
    int early;
    io_rdy = 1'b0;
    issue(3'd4, 1'b1, 26'h40, 4'b1000, 2'd0);
    check("R4 vlio lanes", bs_n, 4'b0111);
    early = 0;
    for (int c = 1; c <= 5; c++) begin
      if (beat_done) early++;
      @(negedge clk);
    end
    check("R8 held while not ready", early, 0);
    io_rdy = 1'b1;
    #1;
    check("R8 beat on ready", beat_done, 1'b1);
    @(negedge clk);
    check("R8 vlio done", busy, 1'b0);
    io_rdy = 1'b0;
    issue(3'd4, 1'b0, 26'h44, 4'b0001, 2'd0);
    @(negedge clk);
    io_rdy = 1'b1;
    n = 2;
    while (!beat_done && n < 64) begin
      @(negedge clk);
      n++;
    end
    check("R8 ready before wait end", n, 3);
    @(negedge clk);
    io_rdy = 1'b0;
    issue(3'd1, 1'b0, 26'h10, 4'hF, 2'd0);
    wait_beat(n);
    check("R8 sram ignores ready", n, 3);
    @(negedge clk);
    io_rdy = 1'b1;
  endtask

  task automatic t_ignore();
    int n;
    issue(3'd6, 1'b0, 26'h0, 4'hF, 2'd0);
    check("R1 bank 6 ignored", {busy, cs_n}, {1'b0, 6'h3F});
    @(negedge clk);
    check("R1 bank 6 still idle", busy, 1'b0);
    issue(3'd1, 1'b0, 26'h20, 4'hF, 2'd0);
    req_valid = 1'b1; req_bank = 3'd4; req_write = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check("R9 busy request ignored", {cs_n, we_n}, {6'b111101, 1'b1});
    wait_beat(n);
    @(negedge clk);
    @(negedge clk);
    check("R9 no queued access", {busy, cs_n}, {1'b0, 6'h3F});
  endtask

  task automatic t_gap();
    int n;
    issue(3'd1, 1'b0, 26'h30, 4'hF, 2'd0);
    wait_beat(n);
    req_valid = 1'b1; req_bank = 3'd0; req_write = 1'b1; req_addr = 26'h4;
    @(negedge clk);
    check("R9 idle gap", {busy, cs_n}, {1'b0, 6'h3F});
    @(negedge clk);
    req_valid = 1'b0;
    check("R9 next access after gap", cs_n, 6'b111110);
    wait_beat(n);
    @(negedge clk);
  endtask

  task automatic finish_up();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    cfg_type  = 12'h7BA;
    cfg_wide  = 6'b111110;
    cfg_wait1 = 24'h321120;
    cfg_waitb = 24'h100000;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_sram_read();
    t_write16();
    t_burst();
    t_illegal();
    t_vlio();
    t_ignore();
    t_gap();
    done = 1;
    finish_up();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      finish_up();
    end
  end

endmodule